// File: doc/BRIEF.md
# I2C byte wait and interrupt controller

This block sits beside the shift and bit-counting logic of an I2C controller. It decides on which SCL falling edge of a byte the controller raises its byte interrupt flag and asks the line driver to hold SCL low, stalling the bus until software has acted. It also decides when that hold is let go. The bus-side logic reports the bit just completed through a 4-bit position (1 to 9, where 8 is the last data bit and 9 the acknowledge bit). It also reports whether the byte is the first one after a start, whether that byte is a reserved address, the received acknowledge level, the receive-FIFO state, the transmit-buffer state, the mode and direction, arbitration loss and bus errors.

Software programs a wait-select bit and an interrupt enable. It clears the flag by writing 0 to it. Writing 0 to master-select or issuing a repeated-start command while the block is active also clears the flag. With wait-select at 0, a data byte stalls after its acknowledge bit; with wait-select at 1, it stalls after the eighth data bit. The first byte, reserved addresses, a NACK during FIFO transmission and a full FIFO during slave reception override that choice. A bus error raises the flag at once but never holds SCL.

Top module: `i2c_byte_wait`

## Requirements
- R1: After reset, int_flag, scl_hold and irq are 0. While en is 0, the flag and the latched bus error are cleared on the next clock edge.
- R2: With wait-select 0, a non-first byte sets the flag on an SCL fall at bit_pos 9 when its wait condition holds, and not at bit_pos 8. The wait condition is: for transmit (is_tx=1), tx_empty; for receive, fifo_en=0; in either direction, arb_lost=1.
- R3: With wait-select 1, a non-first byte sets the flag at bit_pos 8 when its wait condition holds. At bit_pos 9 it sets the flag only through an R5 override.
- R4: For the first byte (first_byte=1), wait-select is ignored. A non-reserved address sets the flag at bit_pos 9. A reserved address (rsv_addr=1) sets the flag at bit_pos 8, whatever the value of fifo_en.
- R5: At bit_pos 9 of a non-first byte, the flag is set whatever the wait-select value in two cases: fifo_en=1 with is_tx=1 and rx_nack=1 (SDA high at acknowledge), and fifo_en=1 with slave reception (is_master=0, is_tx=0) and fifo_full=1. In master reception with fifo_en=1, a full FIFO alone does not set the flag.
- R6: bus_err=1 sets the flag on the next edge regardless of any other input. The error stays latched until the flag is cleared or en goes low.
- R7: scl_hold is 1 exactly while the flag is 1 and no bus error is latched. It falls in the cycle the flag is cleared.
- R8: An int_wr with int_wdata=0 clears the flag. An int_wr with int_wdata=1 sets it only when dma_mode=1, and has no effect when dma_mode=0.
- R9: When the flag is 1 and act=1, an mss_wr with mss_wdata=0 or an scc_set pulse clears the flag. With act=0, neither clears it.
- R10: irq equals the flag ANDed with the stored interrupt enable. cfg_wr loads the wait-select and the enable, and both take effect from the next cycle.
- R11: int_rdata returns 1 while rmw_rd=1, and returns the flag otherwise.
- R12: When a set cause (bus event, bus error or R8 write of 1) and a clear cause occur in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; 0 clears flag and error |
| act | input | 1 | Controller active on the bus (master or addressed slave) |
| scl_fall | input | 1 | One-cycle strobe for an SCL falling edge |
| bit_pos | input | 4 | Bit completed at this fall: 8 last data bit, 9 acknowledge |
| first_byte | input | 1 | Current byte is the first after a (repeated) start |
| rsv_addr | input | 1 | First byte is a reserved address |
| rx_nack | input | 1 | Acknowledge level seen: 1 means NACK |
| fifo_en | input | 1 | FIFO in use |
| fifo_full | input | 1 | Receive FIFO full |
| tx_empty | input | 1 | Transmit buffer empty |
| is_master | input | 1 | 1 master, 0 slave |
| is_tx | input | 1 | 1 transmit direction, 0 receive |
| arb_lost | input | 1 | Arbitration lost in this byte |
| bus_err | input | 1 | Bus error detected |
| dma_mode | input | 1 | DMA mode on; enables software set of the flag |
| cfg_wr | input | 1 | Load wait-select and interrupt enable |
| cfg_wsel | input | 1 | Wait-select: 0 after acknowledge, 1 after 8 data bits |
| cfg_inte | input | 1 | Interrupt enable |
| int_wr | input | 1 | Write strobe for the flag |
| int_wdata | input | 1 | Value written to the flag |
| mss_wr | input | 1 | Write strobe for master-select |
| mss_wdata | input | 1 | Value written to master-select |
| scc_set | input | 1 | Repeated-start command pulse |
| rmw_rd | input | 1 | Current read is a read-modify-write access |
| scl_hold | output | 1 | Request to hold SCL low |
| irq | output | 1 | Interrupt request |
| int_flag | output | 1 | Interrupt flag state |
| int_rdata | output | 1 | Read value of the flag bit |

## Verification
On every cycle the assertions check several relations. Disabling empties the flag, a bus error raises the flag and latches, and a latched error always comes with a raised flag. A set cause beats a clear cause in the same cycle, and irq or scl_hold never appear without the flag. The choice of stall edge between data bit 8 and the acknowledge bit can only be shown by the bench's scenarios. The same holds for the first-byte, reserved-address, NACK and FIFO-full overrides, the master-receive exception, the act qualification of the master-select and repeated-start clears, and the DMA-gated write of 1. The bench drives these cases directly and then through a seeded random mix compared with its own expected state.

// File: rtl/i2cw_pkg.sv
// Package: shared types for the I2C byte wait and interrupt controller.
// Assumes: the bus-side logic supplies mode and direction as two bits.
package i2cw_pkg;

    // Transfer kind seen by the wait decision.
    typedef enum logic [1:0] {
        XFER_MTX = 2'd0,
        XFER_MRX = 2'd1,
        XFER_STX = 2'd2,
        XFER_SRX = 2'd3
    } xfer_e;

    // Bus status bundle sampled at an SCL falling edge.
    typedef struct packed {
        logic  first_byte;
        logic  rsv_addr;
        logic  rx_nack;
        logic  fifo_en;
        logic  fifo_full;
        logic  tx_empty;
        logic  arb_lost;
        xfer_e xfer;
    } bus_stat_t;

    // Map mode and direction bits to the transfer kind.
    function automatic xfer_e xfer_of(input logic is_master, input logic is_tx);
        if (is_master) return is_tx ? XFER_MTX : XFER_MRX;
        return is_tx ? XFER_STX : XFER_SRX;
    endfunction

endpackage

// File: rtl/i2cw_set_decode.sv
// Module: i2cw_set_decode
// Decides whether the SCL falling edge in this cycle raises the byte flag.
// Applies the wait-select choice for data bytes and the overrides for the
// first byte, reserved addresses, FIFO NACK and slave FIFO full.
// Assumes: bit_pos names the bit just completed; scl_fall lasts one cycle.
module i2cw_set_decode
    import i2cw_pkg::*;
#(
    parameter int BIT_W    = 4,
    parameter int DATA_POS = 8,
    parameter int ACK_POS  = 9
) (
    input  logic             scl_fall,
    input  logic [BIT_W-1:0] bit_pos,
    input  bus_stat_t        st,
    input  logic             wsel,
    output logic             set_bit
);
    localparam logic [BIT_W-1:0] POS_DATA = BIT_W'(DATA_POS);
    localparam logic [BIT_W-1:0] POS_ACK  = BIT_W'(ACK_POS);

    logic at_data;
    logic at_ack;
    logic wait_c;
    logic ovr_ack;

    // Locate the edge within the byte.
    always_comb begin
        at_data = scl_fall && (bit_pos == POS_DATA);
        at_ack  = scl_fall && (bit_pos == POS_ACK);
    end

    // Per-transfer wait condition and acknowledge-bit override.
    always_comb begin
        wait_c  = 1'b0;
        ovr_ack = 1'b0;
        case (st.xfer)
            XFER_MTX, XFER_STX: begin
                wait_c  = st.tx_empty;
                ovr_ack = st.fifo_en && st.rx_nack;
            end
            XFER_MRX: begin
                wait_c  = !st.fifo_en;
                ovr_ack = 1'b0;
            end
            XFER_SRX: begin
                wait_c  = !st.fifo_en;
                ovr_ack = st.fifo_en && st.fifo_full;
            end
            default: begin
                wait_c  = 1'b0;
                ovr_ack = 1'b0;
            end
        endcase
        wait_c = wait_c || st.arb_lost;
    end

    // Final set decision: first byte ignores wait-select.
    always_comb begin
        if (st.first_byte) begin
            set_bit = (at_data && st.rsv_addr) || (at_ack && !st.rsv_addr);
        end else begin
            set_bit = (at_data && wsel && wait_c)
                   || (at_ack && (ovr_ack || (!wsel && wait_c)));
        end
    end

endmodule

// File: rtl/i2cw_clear_ctrl.sv
// Module: i2cw_clear_ctrl
// Turns register accesses into software set and clear requests for the flag.
// Assumes: write strobes are single-cycle and qualified by the bus fabric.
module i2cw_clear_ctrl (
    input  logic flag,
    input  logic act,
    input  logic dma_mode,
    input  logic int_wr,
    input  logic int_wdata,
    input  logic mss_wr,
    input  logic mss_wdata,
    input  logic scc_set,
    output logic sw_set,
    output logic sw_clr
);
    logic side_clr;

    // Master-select drop or repeated start ends a pending wait when active.
    always_comb begin
        side_clr = flag && act && ((mss_wr && !mss_wdata) || scc_set);
    end

    // Direct writes: 0 clears, 1 sets only in DMA mode.
    always_comb begin
        sw_set = int_wr && int_wdata && dma_mode;
        sw_clr = (int_wr && !int_wdata) || side_clr;
    end

endmodule

// File: rtl/i2cw_flag_reg.sv
// Module: i2cw_flag_reg
// Holds the byte interrupt flag and the latched bus-error state.
// Set causes win over clear causes; disabling empties both.
// Assumes: synchronous active-low reset, en is already synchronous.
module i2cw_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_bit,
    input  logic bus_err,
    input  logic sw_set,
    input  logic sw_clr,
    output logic flag,
    output logic ber
);
    logic set_any;
    logic do_clr;

    // Combine set causes and the clear that survives them.
    always_comb begin
        set_any = set_bit || bus_err || sw_set;
        do_clr  = sw_clr && !set_any;
    end

    // Flag and error state update.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            flag <= 1'b0;
            ber  <= 1'b0;
        end else begin
            if (set_any)     flag <= 1'b1;
            else if (do_clr) flag <= 1'b0;
            if (bus_err)     ber  <= 1'b1;
            else if (do_clr) ber  <= 1'b0;
        end
    end

    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!flag && !ber));

    p_buserr_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bus_err) |=> (flag && ber));

    p_err_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ber |-> flag);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en && set_bit && sw_clr) |=> flag);

    p_write0_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sw_clr && !set_bit && !bus_err && !sw_set) |=> !flag);

endmodule

// File: rtl/i2c_byte_wait.sv
// Module: i2c_byte_wait (top)
// Byte wait and interrupt controller: decides when the byte flag rises,
// when SCL is held low, and when software actions release it.
// Assumes: all inputs synchronous to clk; scl_fall is a one-cycle strobe.
module i2c_byte_wait
    import i2cw_pkg::*;
#(
    parameter int BIT_W    = 4,
    parameter int DATA_POS = 8,
    parameter int ACK_POS  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             act,
    input  logic             scl_fall,
    input  logic [BIT_W-1:0] bit_pos,
    input  logic             first_byte,
    input  logic             rsv_addr,
    input  logic             rx_nack,
    input  logic             fifo_en,
    input  logic             fifo_full,
    input  logic             tx_empty,
    input  logic             is_master,
    input  logic             is_tx,
    input  logic             arb_lost,
    input  logic             bus_err,
    input  logic             dma_mode,
    input  logic             cfg_wr,
    input  logic             cfg_wsel,
    input  logic             cfg_inte,
    input  logic             int_wr,
    input  logic             int_wdata,
    input  logic             mss_wr,
    input  logic             mss_wdata,
    input  logic             scc_set,
    input  logic             rmw_rd,
    output logic             scl_hold,
    output logic             irq,
    output logic             int_flag,
    output logic             int_rdata
);
    bus_stat_t st;
    logic      wsel_q;
    logic      inte_q;
    logic      set_bit;
    logic      sw_set;
    logic      sw_clr;
    logic      flag;
    logic      ber;

    // Bundle the bus status for the decoder.
    always_comb begin
        st.first_byte = first_byte;
        st.rsv_addr   = rsv_addr;
        st.rx_nack    = rx_nack;
        st.fifo_en    = fifo_en;
        st.fifo_full  = fifo_full;
        st.tx_empty   = tx_empty;
        st.arb_lost   = arb_lost;
        st.xfer       = xfer_of(is_master, is_tx);
    end

    // Configuration bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel_q <= 1'b0;
            inte_q <= 1'b0;
        end else if (cfg_wr) begin
            wsel_q <= cfg_wsel;
            inte_q <= cfg_inte;
        end
    end

    i2cw_set_decode #(
        .BIT_W    (BIT_W),
        .DATA_POS (DATA_POS),
        .ACK_POS  (ACK_POS)
    ) u_dec (
        .scl_fall (scl_fall),
        .bit_pos  (bit_pos),
        .st       (st),
        .wsel     (wsel_q),
        .set_bit  (set_bit)
    );

    i2cw_clear_ctrl u_clr (
        .flag      (flag),
        .act       (act),
        .dma_mode  (dma_mode),
        .int_wr    (int_wr),
        .int_wdata (int_wdata),
        .mss_wr    (mss_wr),
        .mss_wdata (mss_wdata),
        .scc_set   (scc_set),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr)
    );

    i2cw_flag_reg u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .set_bit (set_bit),
        .bus_err (bus_err),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .flag    (flag),
        .ber     (ber)
    );

    // Output drive: hold SCL only on a clean flag, gate the request.
    always_comb begin
        int_flag  = flag;
        scl_hold  = flag && !ber;
        irq       = flag && inte_q;
        int_rdata = rmw_rd ? 1'b1 : flag;
    end

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> int_flag);

    p_hold_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> int_flag);

    p_write1_nodma_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !int_flag && int_wr && int_wdata && !dma_mode && !bus_err && !scl_fall)
        |=> !int_flag);

endmodule

// File: tb/i2c_byte_wait_tb.sv
module i2c_byte_wait_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, act = 1'b0, scl_fall = 1'b0;
    logic [3:0] bit_pos = 4'd0;
    logic first_byte = 1'b0, rsv_addr = 1'b0, rx_nack = 1'b0, fifo_en = 1'b0;
    logic fifo_full = 1'b0, tx_empty = 1'b0, is_master = 1'b0, is_tx = 1'b0;
    logic arb_lost = 1'b0, bus_err = 1'b0, dma_mode = 1'b0;
    logic cfg_wr = 1'b0, cfg_wsel = 1'b0, cfg_inte = 1'b0;
    logic int_wr = 1'b0, int_wdata = 1'b0, mss_wr = 1'b0, mss_wdata = 1'b0;
    logic scc_set = 1'b0, rmw_rd = 1'b0;
    logic scl_hold, irq, int_flag, int_rdata;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    logic m_flag = 1'b0, m_ber = 1'b0, m_wsel = 1'b0, m_inte = 1'b0;

    always #10 clk = ~clk;

    i2c_byte_wait dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .act(act), .scl_fall(scl_fall),
        .bit_pos(bit_pos), .first_byte(first_byte), .rsv_addr(rsv_addr),
        .rx_nack(rx_nack), .fifo_en(fifo_en), .fifo_full(fifo_full),
        .tx_empty(tx_empty), .is_master(is_master), .is_tx(is_tx),
        .arb_lost(arb_lost), .bus_err(bus_err), .dma_mode(dma_mode),
        .cfg_wr(cfg_wr), .cfg_wsel(cfg_wsel), .cfg_inte(cfg_inte),
        .int_wr(int_wr), .int_wdata(int_wdata), .mss_wr(mss_wr),
        .mss_wdata(mss_wdata), .scc_set(scc_set), .rmw_rd(rmw_rd),
        .scl_hold(scl_hold), .irq(irq), .int_flag(int_flag), .int_rdata(int_rdata)
    );

    // Expected bus-side set, written from R2..R5.
    function automatic logic exp_bit_set();
        logic p8, p9, wt, ovr;
        p8 = scl_fall && bit_pos == 4'd8;
        p9 = scl_fall && bit_pos == 4'd9;
        if (first_byte) return (p8 && rsv_addr) || (p9 && !rsv_addr);
        wt  = arb_lost || (is_tx ? tx_empty : !fifo_en);
        ovr = fifo_en && ((is_tx && rx_nack) || (!is_tx && !is_master && fifo_full));
        return (p8 && m_wsel && wt) || (p9 && (ovr || (!m_wsel && wt)));
    endfunction

    task automatic chk(input string tag, input logic [2:0] act_v, input logic [2:0] exp_v);
        total++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act_v, exp_v);
        end
    endtask

    // Advance one clock with the driven inputs, update the model, compare.
    task automatic cycle(input string tag);
        logic nf, nb, sb, cl;
        if (!rst_n || !en) begin
            nf = 1'b0; nb = 1'b0;
        end else begin
            sb = bus_err || exp_bit_set() || (int_wr && int_wdata && dma_mode);
            cl = (int_wr && !int_wdata) ||
                 (m_flag && act && ((mss_wr && !mss_wdata) || scc_set));
            nf = sb ? 1'b1 : (cl ? 1'b0 : m_flag);
            nb = bus_err || (m_ber && !(cl && !sb));
        end
        @(negedge clk);
        m_flag = nf; m_ber = nb;
        if (!rst_n) begin m_wsel = 1'b0; m_inte = 1'b0; end
        else if (cfg_wr) begin m_wsel = cfg_wsel; m_inte = cfg_inte; end
        scl_fall = 1'b0; bus_err = 1'b0; cfg_wr = 1'b0; int_wr = 1'b0;
        mss_wr = 1'b0; scc_set = 1'b0;
        chk(tag, {int_flag, scl_hold, irq}, {m_flag, m_flag && !m_ber, m_flag && m_inte});
    endtask

    task automatic cfg(input logic w, input logic i);
        cfg_wr = 1'b1; cfg_wsel = w; cfg_inte = i;
        cycle("R10");
    endtask

    task automatic fall(input logic [3:0] pos, input string tag);
        scl_fall = 1'b1; bit_pos = pos;
        cycle(tag);
    endtask

    task automatic clr_flag();
        int_wr = 1'b1; int_wdata = 1'b0;
        cycle("R8");
    endtask

    task automatic data_mode(input logic m, input logic t, input logic fe);
        first_byte = 1'b0; rsv_addr = 1'b0; is_master = m; is_tx = t;
        fifo_en = fe; fifo_full = 1'b0; tx_empty = 1'b0; rx_nack = 1'b0; arb_lost = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        cycle("R1"); cycle("R1");
        rst_n = 1'b1; en = 1'b1; act = 1'b1;
        cycle("R1");
        chk("R1 reset state", {int_flag, scl_hold, irq}, 3'b000);

        // R2: wait after acknowledge
        cfg(1'b0, 1'b1);
        data_mode(1'b1, 1'b1, 1'b0); tx_empty = 1'b1;
        fall(4'd8, "R2");
        chk("R2 no set at bit 8", {int_flag, scl_hold, irq}, 3'b000);
        fall(4'd9, "R2");
        chk("R2 set at bit 9 R7 R10", {int_flag, scl_hold, irq}, 3'b111);
        clr_flag();
        chk("R7 release on clear", {int_flag, scl_hold, irq}, 3'b000);
        data_mode(1'b0, 1'b0, 1'b0);
        fall(4'd9, "R2");
        chk("R2 slave rx no fifo", {int_flag, scl_hold}, 3'b011);
        clr_flag();

        // R3: wait after data bits
        cfg(1'b1, 1'b1);
        data_mode(1'b1, 1'b1, 1'b0); tx_empty = 1'b1;
        fall(4'd8, "R3");
        chk("R3 set at bit 8", {1'b0, int_flag, scl_hold}, 3'b011);
        clr_flag();
        fall(4'd9, "R3");
        chk("R3 no set at bit 9", {1'b0, int_flag, scl_hold}, 3'b000);
        data_mode(1'b1, 1'b1, 1'b0); arb_lost = 1'b1;
        fall(4'd8, "R3");
        chk("R3 arbitration lost at bit 8", {2'b00, int_flag}, 3'b001);
        clr_flag();

        // R4: first byte
        data_mode(1'b1, 1'b1, 1'b0); first_byte = 1'b1;
        fall(4'd8, "R4");
        chk("R4 first byte ignores wsel at 8", {2'b00, int_flag}, 3'b000);
        fall(4'd9, "R4");
        chk("R4 first byte sets at 9", {2'b00, int_flag}, 3'b001);
        clr_flag();
        cfg(1'b0, 1'b1);
        rsv_addr = 1'b1; fifo_en = 1'b1;
        fall(4'd8, "R4");
        chk("R4 reserved sets at 8", {2'b00, int_flag}, 3'b001);
        clr_flag();

        // R5: overrides
        cfg(1'b1, 1'b1);
        data_mode(1'b1, 1'b1, 1'b1); rx_nack = 1'b1;
        fall(4'd9, "R5");
        chk("R5 fifo tx nack", {2'b00, int_flag}, 3'b001);
        clr_flag();
        data_mode(1'b0, 1'b0, 1'b1); fifo_full = 1'b1;
        fall(4'd9, "R5");
        chk("R5 slave fifo full", {2'b00, int_flag}, 3'b001);
        clr_flag();
        cfg(1'b0, 1'b1);
        data_mode(1'b1, 1'b0, 1'b1); fifo_full = 1'b1;
        fall(4'd9, "R5");
        chk("R5 master rx full no set", {2'b00, int_flag}, 3'b000);

        // R6: bus error
        bus_err = 1'b1;
        cycle("R6");
        chk("R6 error sets without hold", {int_flag, scl_hold, irq}, 3'b101);
        clr_flag();
        data_mode(1'b1, 1'b1, 1'b0); tx_empty = 1'b1;
        fall(4'd9, "R6");
        chk("R6 error cleared with flag", {int_flag, scl_hold, irq}, 3'b111);
        clr_flag();

        // R8: write 1
        int_wr = 1'b1; int_wdata = 1'b1; dma_mode = 1'b0;
        cycle("R8");
        chk("R8 write1 no dma", {2'b00, int_flag}, 3'b000);
        int_wr = 1'b1; int_wdata = 1'b1; dma_mode = 1'b1;
        cycle("R8");
        chk("R8 write1 dma", {2'b00, int_flag}, 3'b001);
        dma_mode = 1'b0;

        // R9: master-select and repeated start
        mss_wr = 1'b1; mss_wdata = 1'b0;
        cycle("R9");
        chk("R9 mss clear", {2'b00, int_flag}, 3'b000);
        fall(4'd9, "R9");
        scc_set = 1'b1;
        cycle("R9");
        chk("R9 scc clear", {2'b00, int_flag}, 3'b000);
        fall(4'd9, "R9");
        act = 1'b0; scc_set = 1'b1;
        cycle("R9");
        mss_wr = 1'b1; mss_wdata = 1'b0;
        cycle("R9");
        chk("R9 inactive keeps flag", {2'b00, int_flag}, 3'b001);
        act = 1'b1;

        // R10: enable gating
        cfg(1'b0, 1'b0);
        chk("R10 irq gated", {int_flag, scl_hold, irq}, 3'b110);

        // R11: read-modify-write
        clr_flag();
        rmw_rd = 1'b1; #1;
        chk("R11 rmw reads 1", {2'b00, int_rdata}, 3'b001);
        rmw_rd = 1'b0; #1;
        chk("R11 normal read", {2'b00, int_rdata}, 3'b000);

        // R12: set beats clear
        scl_fall = 1'b1; bit_pos = 4'd9; int_wr = 1'b1; int_wdata = 1'b0;
        cycle("R12");
        chk("R12 set wins", {2'b00, int_flag}, 3'b001);

        // R1: disable
        en = 1'b0;
        cycle("R1");
        chk("R1 disable clears", {int_flag, scl_hold, irq}, 3'b000);
        en = 1'b1;

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            scl_fall   = ($urandom % 2) == 0;
            bit_pos    = ($urandom % 3 == 0) ? 4'($urandom % 10) : 4'(8 + $urandom % 2);
            first_byte = ($urandom % 4) == 0;
            rsv_addr   = ($urandom % 3) == 0;
            rx_nack    = 1'($urandom);
            fifo_en    = 1'($urandom);
            fifo_full  = 1'($urandom);
            tx_empty   = 1'($urandom);
            is_master  = 1'($urandom);
            is_tx      = 1'($urandom);
            arb_lost   = ($urandom % 8) == 0;
            bus_err    = ($urandom % 40) == 0;
            dma_mode   = 1'($urandom);
            act        = ($urandom % 4) != 0;
            en         = ($urandom % 50) != 0;
            cfg_wr     = ($urandom % 16) == 0;
            cfg_wsel   = 1'($urandom);
            cfg_inte   = 1'($urandom);
            int_wr     = ($urandom % 6) == 0;
            int_wdata  = 1'($urandom);
            mss_wr     = ($urandom % 10) == 0;
            mss_wdata  = 1'($urandom);
            scc_set    = ($urandom % 10) == 0;
            cycle("R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule